// File: doc/BRIEF.md
# SPI NOR Flash Transaction Monitor

This block watches a serial-flash bus without driving it. An upstream snooper turns the bus into byte events. Each event is either a chip-select change or a data event. A data event carries the byte seen on MOSI and the byte seen on MISO in the same byte slot. The monitor follows each flash command through its phases: opcode, address, dummy and data. It reports the opcode, the assembled 24-bit address and the number of data bytes. It also gives a one-cycle completion pulse when a transaction ends.

The monitor keeps its own copy of the device's write-enable latch across transactions. It uses this copy to flag a program or erase command that arrives without a prior enable. It also flags sector erases that are not aligned to a sector and opcodes outside the supported set. For the dual-I/O read, it separates the bit pairs that travel on the two data lines before it builds the address and counts data.

Top module: `spi_flash_monitor`

## Requirements
- R1: An event with `ev_valid=1, ev_cs=1` ends the transaction in progress, and the next data event is taken as an opcode. If a supported command was open and had not already completed, `xact_done` pulses one cycle after the event.
- R2: The supported opcodes are 0x06 (write enable), 0x04 (write disable), 0x05 (read status), 0x03 (read), 0x0B (fast read), 0x02 (page program), 0x20 (sector erase), 0x60 and 0xC7 (chip erase), 0x9F (read ID) and 0xBB (dual-I/O read). Any other opcode pulses `warn_unknown_op`, opens no transaction and leaves the monitor idle, so the following data byte is again taken as an opcode.
- R3: For read (0x03) and page program (0x02), MOSI bytes 2, 3 and 4 give address bits 23:16, 15:8 and 7:0. Every byte from byte 5 on adds one to `data_count`.
- R4: For fast read (0x0B), byte 5 is a dummy byte and is not counted. Counting starts at byte 6.
- R5: Write enable (0x06) sets the tracked latch and write disable (0x04) clears it. The latch is clear after reset.
- R6: During read status (0x05), every byte after the opcode loads the tracked latch from bit 1 of the MISO byte.
- R7: When the opcode byte is 0x02, 0x20, 0x60 or 0xC7 and the tracked latch is clear, `warn_no_wren` pulses one cycle after that byte.
- R8: Sector erase (0x20) completes on byte 4. In the cycle after byte 4, `xact_done` pulses, and `warn_bad_sector` also pulses if address bits 11:0 are not all zero. Later bytes and the closing chip-select event have no effect on the outputs.
- R9: Read ID (0x9F) completes on byte 4, which pulses `xact_done`. Later bytes are ignored, and the closing chip-select event gives no second pulse.
- R10: For dual-I/O read (0xBB), each byte slot after the opcode gives two bytes. MOSI holds the even bits and MISO the odd bits. The upper nibbles form the first byte and the lower nibbles the second. Slot 2 gives address bits 23:8. In slot 3, the first byte is address bits 7:0 and the second is a dummy. Every slot from slot 4 on adds two to `data_count`.
- R11: `data_count` saturates at 65535.
- R12: `opcode`, `address` and `data_count` are zero after reset. They hold their values across the closing chip-select event. Each new opcode byte loads `opcode` and clears `address` and `data_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_cs | input | 1 | 1: chip-select change event; 0: data event |
| ev_mosi | input | 8 | Byte seen on MOSI for a data event |
| ev_miso | input | 8 | Byte seen on MISO for a data event |
| opcode | output | 8 | Last opcode taken |
| address | output | 24 | Assembled address of the current or last command |
| data_count | output | 16 | Data bytes of the current or last command |
| xact_done | output | 1 | One-cycle pulse when a transaction completes |
| warn_no_wren | output | 1 | One-cycle pulse: program or erase without write enable |
| warn_bad_sector | output | 1 | One-cycle pulse: sector erase address not 4096-aligned |
| warn_unknown_op | output | 1 | One-cycle pulse: unsupported opcode |

## Verification
Each command is driven with its own byte pattern, and the tests are chosen to tell similar commands apart:
- Read and fast read use the same address but a different number of trailing bytes, which exposes any off-by-one in where the dummy byte falls.
- Sector erase is tried at an aligned address and at an address one past a boundary. Extra bytes are sent after it completes to show they are ignored.
- The latch is changed by three routes: write enable, write disable, and read status with MISO bit 1 set and clear. The erase and program warnings then show whether each route took effect.
- Dual-I/O slots are built in the bench from chosen address bytes. A long run of dual slots, which adds two per slot, drives the count past its odd ceiling.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_RD    = 8'h03;
    localparam logic [7:0] OP_FRD   = 8'h0B;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SERA  = 8'h20;
    localparam logic [7:0] OP_CERA1 = 8'h60;
    localparam logic [7:0] OP_CERA2 = 8'hC7;
    localparam logic [7:0] OP_ID    = 8'h9F;
    localparam logic [7:0] OP_DRD   = 8'hBB;

    localparam int ADDR_W = 24;
    localparam int IDX_W  = 3;

    typedef enum logic [3:0] {
        K_NONE, K_WEN, K_WDIS, K_STAT, K_RD, K_FRD,
        K_PROG, K_SERA, K_CERA, K_ID, K_DRD
    } cmd_kind_t;

endpackage

// File: rtl/sfm_op_decode.sv
module sfm_op_decode
    import sfm_pkg::*;
(
    input  logic [7:0] op,
    output cmd_kind_t  kind,
    output logic       needs_wel
);
    always_comb begin
        unique case (op)
            OP_WEN:   kind = K_WEN;
            OP_WDIS:  kind = K_WDIS;
            OP_STAT:  kind = K_STAT;
            OP_RD:    kind = K_RD;
            OP_FRD:   kind = K_FRD;
            OP_PROG:  kind = K_PROG;
            OP_SERA:  kind = K_SERA;
            OP_CERA1: kind = K_CERA;
            OP_CERA2: kind = K_CERA;
            OP_ID:    kind = K_ID;
            OP_DRD:   kind = K_DRD;
            default:  kind = K_NONE;
        endcase
        needs_wel = (kind == K_PROG) || (kind == K_SERA) || (kind == K_CERA);
    end
endmodule

// File: rtl/sfm_dual_unpack.sv
module sfm_dual_unpack (
    input  logic [7:0] even_bits,
    input  logic [7:0] odd_bits,
    output logic [7:0] first_byte,
    output logic [7:0] second_byte
);
    localparam int HALF = 4;
    for (genvar k = 0; k < HALF; k++) begin : g_bit
        assign first_byte[2*k]    = even_bits[HALF + k];
        assign first_byte[2*k+1]  = odd_bits[HALF + k];
        assign second_byte[2*k]   = even_bits[k];
        assign second_byte[2*k+1] = odd_bits[k];
    end
endmodule

// File: rtl/sfm_sat_add.sv
module sfm_sat_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [1:0]   step,
    output logic [W-1:0] sum
);
    logic [W:0] wide;
    always_comb begin
        wide = {1'b0, val} + {{(W-1){1'b0}}, step};
        sum  = wide[W] ? {W{1'b1}} : wide[W-1:0];
    end
endmodule

// File: rtl/spi_flash_monitor.sv
module spi_flash_monitor
    import sfm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SECTOR_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_cs,
    input  logic [7:0]        ev_mosi,
    input  logic [7:0]        ev_miso,
    output logic [7:0]        opcode,
    output logic [ADDR_W-1:0] address,
    output logic [CNT_W-1:0]  data_count,
    output logic              xact_done,
    output logic              warn_no_wren,
    output logic              warn_bad_sector,
    output logic              warn_unknown_op
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic              active;
        logic              fin;
        cmd_kind_t         kind;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              wel;
        logic              done;
        logic              w_wel;
        logic              w_sect;
        logic              w_unk;
    } mon_state_t;

    mon_state_t st_d, st_q;

    cmd_kind_t  new_kind;
    logic       new_needs_wel;
    logic [7:0] dual_hi, dual_lo;
    logic [CNT_W-1:0] cnt_plus;
    logic [1:0] cnt_step;

    sfm_op_decode u_dec (
        .op        (ev_mosi),
        .kind      (new_kind),
        .needs_wel (new_needs_wel)
    );

    sfm_dual_unpack u_dual (
        .even_bits   (ev_mosi),
        .odd_bits    (ev_miso),
        .first_byte  (dual_hi),
        .second_byte (dual_lo)
    );

    assign cnt_step = (st_q.kind == K_DRD) ? 2'd2 : 2'd1;

    sfm_sat_add #(.W(CNT_W)) u_cnt (
        .val  (st_q.cnt),
        .step (cnt_step),
        .sum  (cnt_plus)
    );

    logic [ADDR_W-1:0] addr_byte;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.w_wel  = 1'b0;
        st_d.w_sect = 1'b0;
        st_d.w_unk  = 1'b0;

        addr_byte = st_q.addr;
        case (st_q.idx)
            3'd2:    addr_byte[23:16] = ev_mosi;
            3'd3:    addr_byte[15:8]  = ev_mosi;
            3'd4:    addr_byte[7:0]   = ev_mosi;
            default: ;
        endcase

        if (ev_valid && ev_cs) begin
            st_d.done   = st_q.active && !st_q.fin;
            st_d.active = 1'b0;
            st_d.fin    = 1'b0;
            st_d.idx    = 3'd1;
        end else if (ev_valid && !st_q.active) begin
            st_d.op   = ev_mosi;
            st_d.addr = '0;
            st_d.cnt  = '0;
            if (new_kind == K_NONE) begin
                st_d.w_unk = 1'b1;
                st_d.kind  = K_NONE;
            end else begin
                st_d.active = 1'b1;
                st_d.fin    = 1'b0;
                st_d.kind   = new_kind;
                st_d.idx    = 3'd2;
                st_d.w_wel  = new_needs_wel && !st_q.wel;
                if (new_kind == K_WEN)  st_d.wel = 1'b1;
                if (new_kind == K_WDIS) st_d.wel = 1'b0;
            end
        end else if (ev_valid && !st_q.fin) begin
            if (st_q.idx != IDX_MAX) st_d.idx = st_q.idx + 3'd1;
            case (st_q.kind)
                K_RD, K_PROG, K_FRD: begin
                    if (st_q.idx <= 3'd4)
                        st_d.addr = addr_byte;
                    else if (st_q.kind != K_FRD || st_q.idx >= 3'd6)
                        st_d.cnt = cnt_plus;
                end
                K_SERA: begin
                    st_d.addr = addr_byte;
                    if (st_q.idx == 3'd4) begin
                        st_d.done   = 1'b1;
                        st_d.fin    = 1'b1;
                        st_d.w_sect = (addr_byte[SECTOR_LOG2-1:0] != '0);
                    end
                end
                K_ID: begin
                    if (st_q.idx == 3'd4) begin
                        st_d.done = 1'b1;
                        st_d.fin  = 1'b1;
                    end
                end
                K_STAT: st_d.wel = ev_miso[1];
                K_DRD: begin
                    if (st_q.idx == 3'd2)
                        st_d.addr[23:8] = {dual_hi, dual_lo};
                    else if (st_q.idx == 3'd3)
                        st_d.addr[7:0] = dual_hi;
                    else
                        st_d.cnt = cnt_plus;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= K_NONE;
            st_q.idx  <= 3'd1;
        end else begin
            st_q <= st_d;
        end
    end

    assign opcode          = st_q.op;
    assign address         = st_q.addr;
    assign data_count      = st_q.cnt;
    assign xact_done       = st_q.done;
    assign warn_no_wren    = st_q.w_wel;
    assign warn_bad_sector = st_q.w_sect;
    assign warn_unknown_op = st_q.w_unk;

    AST_CS_ENDS_XACT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_cs) |=> (!st_q.active && st_q.idx == 3'd1)); // R1

    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        warn_unknown_op |-> (!st_q.active && !xact_done)); // R2

    AST_ADDR_HELD_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_cs && st_q.active && st_q.kind == K_RD && st_q.idx >= 3'd5)
        |=> $stable(address)); // R3

    AST_BAD_SECTOR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        warn_bad_sector |-> (opcode == OP_SERA && xact_done
                             && address[SECTOR_LOG2-1:0] != '0)); // R8

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_count == CNT_MAX && !(ev_valid && !ev_cs && !st_q.active))
        |=> data_count == CNT_MAX); // R11

    AST_WARN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warn_no_wren, warn_bad_sector, warn_unknown_op})); // R7

endmodule

// File: tb/spi_flash_monitor_bench.sv
module spi_flash_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_cs = 1'b0;
    logic [7:0]  ev_mosi = '0;
    logic [7:0]  ev_miso = '0;
    logic [7:0]  opcode;
    logic [23:0] address;
    logic [15:0] data_count;
    logic        xact_done, warn_no_wren, warn_bad_sector, warn_unknown_op;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic p_done, p_wel, p_sect, p_unk;

    always #4 clk = ~clk;

    spi_flash_monitor u_spi_flash_monitor (
        .clk, .rst_n, .ev_valid, .ev_cs, .ev_mosi, .ev_miso,
        .opcode, .address, .data_count, .xact_done,
        .warn_no_wren, .warn_bad_sector, .warn_unknown_op
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic cs, input logic [7:0] mo, input logic [7:0] mi);
        @(negedge clk);
        ev_valid = 1'b1; ev_cs = cs; ev_mosi = mo; ev_miso = mi;
        @(negedge clk);
        p_done = xact_done; p_wel = warn_no_wren;
        p_sect = warn_bad_sector; p_unk = warn_unknown_op;
        ev_valid = 1'b0; ev_cs = 1'b0;
    endtask

    task automatic byte_ev(input logic [7:0] mo, input logic [7:0] mi = 8'h00);
        send(1'b0, mo, mi);
    endtask

    task automatic cs_ev();
        send(1'b1, 8'h00, 8'h00);
    endtask

    function automatic logic [3:0] evens(input logic [7:0] b);
        return {b[6], b[4], b[2], b[0]};
    endfunction
    function automatic logic [3:0] odds(input logic [7:0] b);
        return {b[7], b[5], b[3], b[1]};
    endfunction

    task automatic dual_slot(input logic [7:0] b1, input logic [7:0] b2);
        byte_ev({evens(b1), evens(b2)}, {odds(b1), odds(b2)});
    endtask

    task automatic t_reset();
        check("R12 reset opcode", opcode, 0);
        check("R12 reset address", address, 0);
        check("R12 reset count", data_count, 0);
        check("R1 reset done", xact_done, 0);
    endtask

    task automatic t_program();
        byte_ev(8'h02);
        check("R7 PP without enable warns", p_wel, 1);
        check("R5 latch clear after reset", p_wel, 1);
        cs_ev();
        check("R1 done on cs", p_done, 1);
        byte_ev(8'h06); cs_ev();
        byte_ev(8'h02);
        check("R5 enable suppresses warning", p_wel, 0);
        byte_ev(8'h12); byte_ev(8'h34); byte_ev(8'h56);
        check("R3 address assembled", address, 32'h123456);
        check("R3 no count in address phase", data_count, 0);
        byte_ev(8'hA1); byte_ev(8'hA2); byte_ev(8'hA3);
        check("R3 program count", data_count, 3);
        check("R1 no done mid transaction", p_done, 0);
        cs_ev();
        check("R1 done at close", p_done, 1);
        check("R12 opcode held", opcode, 8'h02);
        check("R12 address held", address, 32'h123456);
        check("R12 count held", data_count, 3);
    endtask

    task automatic t_reads();
        byte_ev(8'h03);
        check("R12 new opcode clears address", address, 0);
        check("R12 new opcode clears count", data_count, 0);
        byte_ev(8'hAB); byte_ev(8'hCD); byte_ev(8'hEF);
        byte_ev(8'h00, 8'h11); byte_ev(8'h00, 8'h22);
        check("R3 read count", data_count, 2);
        check("R3 read address", address, 32'hABCDEF);
        cs_ev();
        byte_ev(8'h0B);
        byte_ev(8'hAB); byte_ev(8'hCD); byte_ev(8'hEF);
        byte_ev(8'h00);
        check("R4 dummy not counted", data_count, 0);
        byte_ev(8'h00); byte_ev(8'h00); byte_ev(8'h00);
        check("R4 fast read count", data_count, 3);
        cs_ev();
    endtask

    task automatic t_latch();
        byte_ev(8'h04); cs_ev();
        byte_ev(8'h20);
        check("R5 disable then erase warns", p_wel, 1);
        cs_ev();
        byte_ev(8'h05); byte_ev(8'h00, 8'h02); cs_ev();
        byte_ev(8'h60);
        check("R6 status bit1 set latch", p_wel, 0);
        cs_ev();
        byte_ev(8'h05); byte_ev(8'h00, 8'hFD); cs_ev();
        byte_ev(8'hC7);
        check("R6 status bit1 clear latch", p_wel, 1);
        cs_ev();
    endtask

    task automatic t_sector();
        byte_ev(8'h06); cs_ev();
        byte_ev(8'h20);
        byte_ev(8'h00); byte_ev(8'h10);
        check("R8 no done before byte 4", p_done, 0);
        byte_ev(8'h00);
        check("R8 done on byte 4", p_done, 1);
        check("R8 aligned no warning", p_sect, 0);
        byte_ev(8'h77);
        check("R8 later byte ignored", address, 32'h001000);
        cs_ev();
        check("R8 no second done", p_done, 0);
        byte_ev(8'h20);
        byte_ev(8'h00); byte_ev(8'h10); byte_ev(8'h01);
        check("R8 misaligned warns", p_sect, 1);
        check("R8 misaligned done", p_done, 1);
        cs_ev();
    endtask

    task automatic t_id();
        byte_ev(8'h9F);
        byte_ev(8'h00, 8'hC2); byte_ev(8'h00, 8'h20);
        check("R9 no done at byte 3", p_done, 0);
        byte_ev(8'h00, 8'h16);
        check("R9 done at byte 4", p_done, 1);
        byte_ev(8'h00, 8'h55);
        check("R9 later byte ignored", p_done, 0);
        cs_ev();
        check("R9 no done at close", p_done, 0);
    endtask

    task automatic t_unknown();
        byte_ev(8'hFF);
        check("R2 unknown flagged", p_unk, 1);
        check("R2 opcode shows byte", opcode, 8'hFF);
        byte_ev(8'h03);
        check("R2 next byte is opcode", opcode, 8'h03);
        check("R2 known no flag", p_unk, 0);
        cs_ev();
        check("R1 done after read open", p_done, 1);
        byte_ev(8'hFF); cs_ev();
        check("R2 no done for unknown", p_done, 0);
    endtask

    task automatic t_dual();
        byte_ev(8'hBB);
        dual_slot(8'h9A, 8'h5C);
        dual_slot(8'h3E, 8'hF0);
        check("R10 dual address", address, 32'h9A5C3E);
        check("R10 dummy not counted", data_count, 0);
        dual_slot(8'h01, 8'h02); dual_slot(8'h03, 8'h04); dual_slot(8'h05, 8'h06);
        check("R10 dual count", data_count, 6);
        cs_ev();
    endtask

    task automatic t_saturate();
        byte_ev(8'hBB);
        dual_slot(8'h00, 8'h00); dual_slot(8'h00, 8'h00);
        @(negedge clk);
        ev_valid = 1'b1; ev_cs = 1'b0; ev_mosi = 8'h00; ev_miso = 8'h00;
        repeat (32767) @(negedge clk);
        ev_valid = 1'b0;
        check("R11 below ceiling", data_count, 65534);
        dual_slot(8'h00, 8'h00);
        check("R11 clamps at ceiling", data_count, 65535);
        dual_slot(8'h00, 8'h00);
        check("R11 stays at ceiling", data_count, 65535);
        cs_ev();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_reads();
        t_latch();
        t_sector();
        t_id();
        t_unknown();
        t_dual();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule